// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This unit sits beside an adder/subtractor and turns one add or subtract into six status bits: carry, overflow, sign, zero, auxiliary carry and parity. It takes both operands, the full result word and an add/subtract select. From these it rebuilds the carry chain at the operation width, which is 8, 16 or 32 bits and is chosen for each operation. The flags go into a six-bit register when the update strobe is high at a clock edge.

The register is visible as a whole vector. Each flag can also be read as a single bit through an index. The unit never computes the result itself. The ALU supplies a result that matches the operands.

Top module: `flgu_status_unit`

## Requirements
- R1: Carry is the carry out of the selected-width MSB on add, and the borrow (unsigned first operand less than second) on subtract; it sits at flag bit 0.
- R2: Overflow (bit 5) is set on add when both operands share a sign and the result sign differs; on subtract when operand signs differ and the result sign differs from the first operand.
- R3: Sign (bit 4) equals the result MSB of the selected width.
- R4: Zero (bit 3) is set exactly when the result bits of the selected width are all zero.
- R5: Auxiliary carry (bit 2) is set on add when the low nibbles carry into bit 4, and on subtract when the low nibble of the first operand is below that of the second.
- R6: Parity (bit 1) is set when the low 8 result bits hold an even number of ones, for every width.
- R7: Width select 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits; operand and result bits above the selected width do not affect any flag.
- R8: The flags register resets to all zeros and changes only at a rising clock edge with the update strobe high.
- R9: The read-back bit returns register bit rd_sel for indices 0 to 5 and 0 for indices 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| op_res | input | DATA_W | Result of op_a plus or minus op_b |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| wsel | input | 2 | Operation width select |
| upd | input | 1 | Flags register update strobe |
| rd_sel | input | SEL_W | Read-back flag index |
| flags_o | output | 6 | Flags register {ovf,sgn,zro,aux,par,cry} |
| rd_bit | output | 1 | Selected flag bit |

## Verification
Every flag is registered, so a wrong lane choice or a wrong carry reconstruction shows up on flags_o one edge after the strobe that loaded it. A register that loads without the strobe shows up as a change on flags_o during hold cycles. A read-back mux with the wrong index shows up on rd_bit combinationally, in the same cycle the index is applied. Upper-bit garbage is driven on narrow operations so that a lane that leaks wider bits changes sign, zero or carry at once.

// File: rtl/flgu_pkg.sv
package flgu_pkg;
    localparam int FLAG_N = 6;

    typedef struct packed {
        logic ovf;  // bit 5
        logic sgn;  // bit 4
        logic zro;  // bit 3
        logic aux;  // bit 2
        logic par;  // bit 1
        logic cry;  // bit 0
    } flags_t;
endpackage

// File: rtl/flgu_lane.sv
module flgu_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] r,
    input  logic              sub,
    output logic              cry,
    output logic              ovf,
    output logic              sgn,
    output logic              zro
);
    localparam int M = LANE_W - 1;

    logic bx_m;
    logic cin_m;
    logic cout;

    always_comb begin
        bx_m  = b[M] ^ sub;
        cin_m = a[M] ^ bx_m ^ r[M];
        cout  = (a[M] & bx_m) | (a[M] & cin_m) | (bx_m & cin_m);
        cry   = cout ^ sub;
        ovf   = cin_m ^ cout;
        sgn   = r[M];
        zro   = ~|r;
    end

    always_comb begin
        if (!$isunknown({a, b, r, sub})) begin
            if (!sub) begin
                AST_OVF_ADD_SIGNS: assert (ovf == ((a[M] == b[M]) && (r[M] != a[M]))); // R2
            end else begin
                AST_BORROW_UNSIGNED: assert (cry == (a < b)); // R1
            end
        end
    end
endmodule

// File: rtl/flgu_readback.sv
module flgu_readback #(
    parameter int FLAG_N = 6,
    parameter int SEL_W  = 3
) (
    input  logic [FLAG_N-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < FLAG_N; i++) begin
            if (sel == SEL_W'(i)) bit_o = flags[i];
        end
    end
endmodule

// File: rtl/flgu_status_unit.sv
module flgu_status_unit
    import flgu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_res,
    input  logic              op_sub,
    input  logic [1:0]        wsel,
    input  logic              upd,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [5:0]        flags_o,
    output logic              rd_bit
);
    localparam int LANES = $clog2(DATA_W / 8) + 1;

    logic [LANES-1:0] lane_cry, lane_ovf, lane_sgn, lane_zro;
    logic [1:0]       lane_idx;
    flags_t           flags_d, flags_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LW = 8 << k;
        flgu_lane #(.LANE_W(LW)) u_lane (
            .a   (op_a[LW-1:0]),
            .b   (op_b[LW-1:0]),
            .r   (op_res[LW-1:0]),
            .sub (op_sub),
            .cry (lane_cry[k]),
            .ovf (lane_ovf[k]),
            .sgn (lane_sgn[k]),
            .zro (lane_zro[k])
        );
    end

    always_comb begin
        lane_idx = (wsel >= 2'(LANES)) ? 2'(LANES - 1) : wsel;
        flags_d  = flags_q;
        if (upd) begin
            flags_d.cry = lane_cry[lane_idx];
            flags_d.ovf = lane_ovf[lane_idx];
            flags_d.sgn = lane_sgn[lane_idx];
            flags_d.zro = lane_zro[lane_idx];
            // carry into bit 4; the subtract inversion cancels out
            flags_d.aux = op_a[4] ^ op_b[4] ^ op_res[4];
            flags_d.par = ~^op_res[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    flgu_readback #(.FLAG_N(FLAG_N), .SEL_W(SEL_W)) u_rdbk (
        .flags (flags_q),
        .sel   (rd_sel),
        .bit_o (rd_bit)
    );

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags_o)); // R8
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[3] |-> !flags_o[4]); // R4
    AST_RDBK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel >= SEL_W'(FLAG_N)) |-> !rd_bit); // R9
    AST_RDBK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_W'(0)) |-> (rd_bit == flags_o[0])); // R9
endmodule

// File: tb/test_flgu_status_unit.sv
module test_flgu_status_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_res = '0;
    logic        op_sub = 1'b0;
    logic [1:0]  wsel = 2'd0;
    logic        upd = 1'b0;
    logic [2:0]  rd_sel = 3'd0;
    logic [5:0]  flags_o;
    logic        rd_bit;

    int total = 0;
    int fails = 0;
    logic [5:0] last_exp = '0;

    always #(CLK_P / 2) clk = ~clk;

    flgu_status_unit i_flgu_status_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_res(op_res),
        .op_sub(op_sub), .wsel(wsel), .upd(upd), .rd_sel(rd_sel),
        .flags_o(flags_o), .rd_bit(rd_bit)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected flags {ovf,sgn,zro,aux,par,cry}
    function automatic logic [5:0] exp_f(logic [31:0] a, logic [31:0] b, logic sub, logic [1:0] ws);
        int w;
        longint unsigned m, aw, bw, r, rw;
        logic c, v, s, z, af, p, sa, sb;
        w  = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
        m  = (64'd1 << w) - 64'd1;
        aw = a & m;
        bw = b & m;
        if (!sub) begin
            r  = aw + bw;
            c  = ((r >> w) & 64'd1) != 0;
            af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        end else begin
            r  = aw - bw;
            c  = aw < bw;
            af = a[3:0] < b[3:0];
        end
        rw = r & m;
        s  = ((rw >> (w - 1)) & 64'd1) != 0;
        sa = ((aw >> (w - 1)) & 64'd1) != 0;
        sb = ((bw >> (w - 1)) & 64'd1) != 0;
        v  = sub ? ((sa != sb) && (s != sa)) : ((sa == sb) && (s != sa));
        z  = (rw == 0);
        p  = ($countones(rw & 64'hFF) % 2) == 0;
        return {v, s, z, af, p, c};
    endfunction

    task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic sub, logic [1:0] ws);
        @(negedge clk);
        op_a = a; op_b = b; op_sub = sub; wsel = ws;
        op_res = sub ? (a - b) : (a + b);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        last_exp = exp_f(a, b, sub, ws);
        check(req, {26'd0, flags_o}, {26'd0, last_exp});
    endtask

    task automatic t_reset();
        check("R8 reset flags", {26'd0, flags_o}, 32'd0);
        check("R9 reset readback", {31'd0, rd_bit}, 32'd0);
    endtask

    task automatic t_add8();
        run_op("R1 R5 R6 8b add ff+01", 32'h0000_00FF, 32'h0000_0001, 1'b0, 2'd0);
        check("R4 zero set", {31'd0, flags_o[3]}, 32'd1);
        check("R1 carry set", {31'd0, flags_o[0]}, 32'd1);
        run_op("R2 R3 8b add 7f+01", 32'h0000_007F, 32'h0000_0001, 1'b0, 2'd0);
        check("R2 overflow set", {31'd0, flags_o[5]}, 32'd1);
        run_op("R2 8b add 80+80", 32'h0000_0080, 32'h0000_0080, 1'b0, 2'd0);
    endtask

    task automatic t_sub8();
        run_op("R1 R5 8b sub 10-21", 32'h0000_0010, 32'h0000_0021, 1'b1, 2'd0);
        check("R1 borrow set", {31'd0, flags_o[0]}, 32'd1);
        run_op("R2 8b sub 80-01", 32'h0000_0080, 32'h0000_0001, 1'b1, 2'd0);
        check("R2 sub overflow", {31'd0, flags_o[5]}, 32'd1);
        run_op("R4 8b sub 55-55", 32'h0000_0055, 32'h0000_0055, 1'b1, 2'd0);
    endtask

    task automatic t_widths();
        run_op("R7 16b add", 32'h0000_8000, 32'h0000_8000, 1'b0, 2'd1);
        run_op("R7 16b sub", 32'h0000_1234, 32'h0000_5678, 1'b1, 2'd1);
        run_op("R7 32b add", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'd2);
        run_op("R7 32b sub sel3", 32'h0000_0000, 32'h0000_0001, 1'b1, 2'd3);
        run_op("R6 32b parity low byte", 32'hFF00_0000, 32'h0000_0003, 1'b0, 2'd2);
    endtask

    task automatic t_upper_ignored();
        run_op("R7 8b upper garbage", 32'hABCD_EF00, 32'h1234_5600, 1'b0, 2'd0);
        check("R7 zero despite upper", {31'd0, flags_o[3]}, 32'd1);
        run_op("R7 16b upper garbage", 32'hFFFF_7FFF, 32'h8000_0001, 1'b0, 2'd1);
    endtask

    task automatic t_hold();
        logic [5:0] held;
        run_op("R8 load before hold", 32'h0000_00FF, 32'h0000_0001, 1'b0, 2'd0);
        held = flags_o;
        @(negedge clk);
        op_a = 32'h0000_0001; op_b = 32'h0000_0001; op_res = 32'h0000_0002;
        op_sub = 1'b0; upd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 hold without strobe", {26'd0, flags_o}, {26'd0, held});
    endtask

    task automatic t_readback();
        run_op("R9 load for readback", 32'h0000_007F, 32'h0000_0001, 1'b0, 2'd0);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            check("R9 readback bit", {31'd0, rd_bit}, (i < 6) ? {31'd0, last_exp[i]} : 32'd0);
        end
        rd_sel = 3'd0;
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_P * 2 + 2);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add8();
        t_sub8();
        t_widths();
        t_upper_ignored();
        t_hold();
        t_readback();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule